// File: doc/BRIEF.md
# Two-Digit Decimal Adder

This block adds two packed decimal numbers of two digits each and returns a packed decimal sum of the same width. Each operand carries its tens digit in the upper nibble and its units digit in the lower nibble. The block has no carry-out port. Any carry out of the tens digit is dropped, so the result wraps modulo 100.

The adder is purely combinational. It is assembled structurally from bit-level gates in three layers. A one-bit full adder sits at the bottom. A single-digit decimal adder forms a 4-bit binary sum and then applies decimal correction. The top level chains the digit adders through their decimal carries, and the units digit takes a carry-in of zero. No word-level arithmetic operator appears anywhere in the hierarchy. The digit count is a parameter with a default of two.

Only operands whose nibbles are all in the range 0 to 9 are meaningful. Other patterns are never applied.

Top module: `bcd_pair_adder`

## Requirements
- R1: Operand and result nibbles are packed with the tens digit in bits [7:4] and the units digit in bits [3:0] (for example, 09 plus 01 yields 8'h10).
- R2: For every pair of valid operands, sum_bcd holds the decimal value (A + B) mod 100, encoded as in R1.
- R3: The units digit of sum_bcd equals (units of A + units of B) mod 10 and does not depend on the tens digits.
- R4: The tens digit of sum_bcd equals (tens of A + tens of B + k) mod 10, where k is 1 exactly when the units digits of A and B sum to 10 or more.
- R5: When A + B is 100 or more, the hundreds carry is discarded (99 plus 01 gives 00, 50 plus 50 gives 00), and the carry out of the top digit is 1 exactly in that case.
- R6: For valid operands, each nibble of sum_bcd lies in the range 0 to 9.
- R7: The block holds no state. The result depends only on the present operands, whatever was applied before.
- R8: The addition is commutative: swapping a_bcd and b_bcd leaves sum_bcd unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_bcd | input | 8 | First operand, two packed decimal digits |
| b_bcd | input | 8 | Second operand, two packed decimal digits |
| sum_bcd | output | 8 | Packed decimal sum, modulo 100 |

## Verification
The block has no registers, so a fault in its carry chain or its correction detect appears at sum_bcd in the same evaluation as the operands that expose it. The fault may hide, though. A wrong "ten or more" term changes only the pairs whose digit sums land in the range that term decodes. A broken inter-digit carry changes only the pairs whose units sum to 10 or more. For this reason the bench sweeps all 10,000 valid pairs, applying each pair in both orders. It also checks the units digit, the tens digit and the wrap case separately, so that a failure points to the faulty layer.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] digit_t;

    // Raw 4-bit binary sum of two digits plus its carry out of bit 3
    typedef struct packed {
        logic   carry;
        digit_t bits;
    } nib_sum_t;

    // Gate-level test for a raw digit sum of ten or more
    function automatic logic needs_fix(nib_sum_t r);
        return r.carry | (r.bits[3] & r.bits[2]) | (r.bits[3] & r.bits[1]);
    endfunction

endpackage

// File: rtl/bcd_fa.sv
module bcd_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic sum,
    output logic co
);
    logic p;

    assign p   = x ^ y;
    assign sum = p ^ ci;
    assign co  = (x & y) | (p & ci);
endmodule

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
    import bcd_pkg::*;
(
    input  digit_t x,
    input  digit_t y,
    input  logic   ci,
    output digit_t digit,
    output logic   dec_carry
);
    logic [DIGIT_W:0] rc;
    digit_t           raw_bits;
    nib_sum_t         raw;
    logic             fix;
    logic [3:1]       cc;

    assign rc[0] = ci;

    // Binary ripple over the digit
    for (genvar i = 0; i < DIGIT_W; i++) begin : g_raw
        bcd_fa u_fa (
            .x  (x[i]),
            .y  (y[i]),
            .ci (rc[i]),
            .sum(raw_bits[i]),
            .co (rc[i+1])
        );
    end

    assign raw.carry = rc[DIGIT_W];
    assign raw.bits  = raw_bits;
    assign fix       = needs_fix(raw);
    assign dec_carry = fix;

    // Add six (0110) when fix is set: bit 0 passes through, bits 1..2 add fix, bit 3 takes the ripple
    assign digit[0] = raw_bits[0];
    assign cc[1]    = 1'b0;

    for (genvar j = 1; j < 3; j++) begin : g_fix
        bcd_fa u_fa (
            .x  (raw_bits[j]),
            .y  (fix),
            .ci (cc[j]),
            .sum(digit[j]),
            .co (cc[j+1])
        );
    end

    assign digit[3] = raw_bits[3] ^ cc[3];
endmodule

// File: rtl/bcd_pair_adder.sv
module bcd_pair_adder
    import bcd_pkg::*;
#(
    parameter int NDIGITS = 2,
    localparam int W = DIGIT_W * NDIGITS
) (
    input  logic [W-1:0] a_bcd,
    input  logic [W-1:0] b_bcd,
    output logic [W-1:0] sum_bcd
);
    logic [NDIGITS:0] chain;

    assign chain[0] = 1'b0;

    for (genvar d = 0; d < NDIGITS; d++) begin : g_digit
        bcd_digit_add u_dig (
            .x        (a_bcd[DIGIT_W*d +: DIGIT_W]),
            .y        (b_bcd[DIGIT_W*d +: DIGIT_W]),
            .ci       (chain[d]),
            .digit    (sum_bcd[DIGIT_W*d +: DIGIT_W]),
            .dec_carry(chain[d+1])
        );
    end
endmodule

// File: rtl/bcd_pair_adder_chk.sv
module bcd_pair_adder_chk #(
    parameter int NDIGITS = 2,
    localparam int W = 4 * NDIGITS
) (
    input logic [W-1:0] a_bcd,
    input logic [W-1:0] b_bcd,
    input logic [W-1:0] sum_bcd,
    input logic         top_carry
);
    int   a_val, b_val, s_val, modulus;
    logic known, in_range, digits_ok;

    always_comb begin
        a_val = 0; b_val = 0; s_val = 0; modulus = 1;
        in_range = 1'b1; digits_ok = 1'b1;
        for (int d = NDIGITS - 1; d >= 0; d--) begin
            a_val   = a_val * 10 + int'(a_bcd[4*d +: 4]);
            b_val   = b_val * 10 + int'(b_bcd[4*d +: 4]);
            s_val   = s_val * 10 + int'(sum_bcd[4*d +: 4]);
            modulus = modulus * 10;
            in_range  = in_range & (a_bcd[4*d +: 4] <= 4'd9) & (b_bcd[4*d +: 4] <= 4'd9);
            digits_ok = digits_ok & (sum_bcd[4*d +: 4] <= 4'd9);
        end
        known = !$isunknown({a_bcd, b_bcd, sum_bcd, top_carry});
    end

    always_comb begin
        if (known && in_range) begin
            // R6
            digit_range_chk: assert (digits_ok);
            // R2
            modular_sum_chk: assert (s_val == (a_val + b_val) % modulus);
            // R3
            units_digit_chk: assert (int'(sum_bcd[3:0]) ==
                                     (int'(a_bcd[3:0]) + int'(b_bcd[3:0])) % 10);
            // R5
            dropped_carry_chk: assert (top_carry == ((a_val + b_val) >= modulus));
        end
    end
endmodule

bind bcd_pair_adder bcd_pair_adder_chk #(.NDIGITS(NDIGITS)) u_chk (
    .a_bcd    (a_bcd),
    .b_bcd    (b_bcd),
    .sum_bcd  (sum_bcd),
    .top_carry(chain[NDIGITS])
);

// File: tb/bcd_pair_adder_test.sv
`timescale 1ns/1ps
module bcd_pair_adder_test;
    logic       clk = 1'b0;
    logic [7:0] a_in = 8'h00;
    logic [7:0] b_in = 8'h00;
    logic [7:0] s_out;
    int         checks = 0;
    int         fails  = 0;
    logic       done   = 1'b0;

    always #2.5 clk = ~clk;

    bcd_pair_adder uut (
        .a_bcd  (a_in),
        .b_bcd  (b_in),
        .sum_bcd(s_out)
    );

    function automatic logic [7:0] ref_sum(logic [7:0] a, logic [7:0] b);
        int av, bv, sv;
        av = 10 * int'(a[7:4]) + int'(a[3:0]);
        bv = 10 * int'(b[7:4]) + int'(b[3:0]);
        sv = av + bv;
        return {4'((sv / 10) % 10), 4'(sv % 10)};
    endfunction

    task automatic check(string tag, logic [7:0] a, logic [7:0] b,
                         logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", tag, a, b, act, exp);
        end
    endtask

    task automatic apply(logic [7:0] a, logic [7:0] b);
        @(posedge clk);
        a_in = a;
        b_in = b;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] first;

        // Zero operands: reset-like state (R2)
        apply(8'h00, 8'h00);
        check("R2", 8'h00, 8'h00, s_out, 8'h00);
        // R1 packing: carry lands in the upper nibble
        apply(8'h09, 8'h01);
        check("R1", 8'h09, 8'h01, s_out, 8'h10);
        // R5 wrap cases
        apply(8'h99, 8'h01);
        check("R5", 8'h99, 8'h01, s_out, 8'h00);
        apply(8'h50, 8'h50);
        check("R5", 8'h50, 8'h50, s_out, 8'h00);
        // R7 no state: same operands after different histories
        apply(8'h99, 8'h99);
        apply(8'h00, 8'h00);
        check("R7", 8'h00, 8'h00, s_out, 8'h00);
        apply(8'h45, 8'h55);
        apply(8'h00, 8'h00);
        check("R7", 8'h00, 8'h00, s_out, 8'h00);

        // Exhaustive sweep over valid operand pairs
        for (int ta = 0; ta < 10; ta++)
            for (int ua = 0; ua < 10; ua++)
                for (int tb = 0; tb < 10; tb++)
                    for (int ub = 0; ub < 10; ub++) begin
                        logic [7:0] a, b, e;
                        int k;
                        a = {4'(ta), 4'(ua)};
                        b = {4'(tb), 4'(ub)};
                        e = ref_sum(a, b);
                        k = (ua + ub >= 10) ? 1 : 0;
                        apply(a, b);
                        first = s_out;
                        check("R2", a, b, s_out, e);
                        check("R3", a, b, {4'h0, s_out[3:0]}, {4'h0, 4'((ua + ub) % 10)});
                        check("R4", a, b, {4'h0, s_out[7:4]}, {4'h0, 4'((ta + tb + k) % 10)});
                        check("R6", a, b, {7'h0, (s_out[7:4] <= 4'd9) && (s_out[3:0] <= 4'd9)}, 8'h01);
                        if (10 * (ta + tb) + ua + ub >= 100)
                            check("R5", a, b, s_out, e);
                        apply(b, a);
                        check("R8", b, a, s_out, first);
                    end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule